// File: doc/BRIEF.md
# Timer count-clock selector

This block decides, on every system-clock cycle, whether one channel of a 16-bit timer should advance its counter. It emits a single-cycle enable, `cnt_en`. Where that enable comes from depends on a 3-bit source code. The possible sources are: the undivided system clock, a prescaled rate taken from a free-running shared divider (divide by 4, 16, 64, 256, 1024 or 4096), one of four external pins, or the overflow/underflow pulse of a neighbouring channel. A per-channel parameter gives the code-to-source map. A second parameter is the mask of codes that are legal on that channel. The counter itself, compare and capture logic, and register access all live outside this block.

A 2-bit edge-mode field selects whether a prescaled rate or an external pin counts on rising transitions, falling transitions or both. Edge mode has no effect on the undivided clock or on the cascade pulse. When the channel supports phase counting and the phase-counting input is high, the whole selection is overridden and this block stays silent. When the code or the edge mode changes, the change takes effect one cycle later. In the cycle of the change no count is produced, so a level difference between the old source and the new one cannot turn into a false edge.

Top module: `cnt_clk_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cnt_en` is 0 after that edge. Reset returns the free-running divider, the pin synchronizers and the edge history to 0, and returns the remembered code and edge mode to 0.
- R2: When the code selects the undivided system clock (code 0 by default), `cnt_en` is 1 after every clock edge whose configuration matches the previous edge, whatever the edge mode.
- R3: Let d be the number of clock edges since reset was released. For a prescaled rate N (codes 1, 2, 3 select N = 4, 16, 64 by default), `cnt_en` is 1 after the edge that moves the count from d to d+1. With edge mode 00 (rising) this happens when d mod N = N/2. With edge mode 01 (falling) it happens when d mod N = 0 and d > 0.
- R4: Edge mode 10 or 11 (both) on a prescaled rate N gives a pulse at every d that satisfies either rule of R3. For N = 4 this means one pulse every 2 cycles.
- R5: The external pins pass through a two-flop synchronizer (codes 4 and 5 select pins 0 and 1 by default). A pin transition that is driven between clock edges and that matches the edge mode makes `cnt_en` high for exactly one cycle, after the third clock edge that follows the transition.
- R6: When the code selects the cascade source (code 7 by default), `cnt_en` after an edge equals `casc_pulse` at that edge, whatever the edge mode.
- R7: A code whose bit in the legal mask is 0 (code 6 by default) never produces a count.
- R8: On a channel built with phase counting enabled, `phase_mode` high at an edge forces `cnt_en` to 0 after that edge, for every code and edge mode.
- R9: If the code or the edge mode at an edge differs from its value at the previous edge, `cnt_en` is 0 after that edge. The new setting applies from the next edge on.
- R10: For a prescaled rate with a steady code, `cnt_en` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psc_code | input | 3 | Count-source code |
| edge_mode | input | 2 | 00 rising, 01 falling, 1x both |
| phase_mode | input | 1 | Phase-counting override |
| ext_pin | input | 4 | Asynchronous external clock pins |
| casc_pulse | input | 1 | Overflow/underflow pulse of the neighbouring channel |
| cnt_en | output | 1 | Single-cycle count enable |

## Verification
The hardest situation to create is a configuration switch in the one cycle where the old source and the new source sit at different levels. That is where a missing history re-sample would leak a false count. The bench sweeps every code against every edge mode in turn, so each switch lands at a different phase of the shared divider and of the pseudo-random pin pattern. A directed run then flips between two prescaled rates every three cycles, and another flips between a pin and a rate, to hit mismatched levels many times. The expected enable is computed from the edge count since reset and from the bench's own history of driven pin values.

// File: rtl/cnt_clk_pkg.sv
// Package: shared constants and types for the timer count-clock selector.
// Source identifiers: 0 = undivided clock, 1..NUM_RATES-1 = divide by 4**id,
// SRC_PIN0.. = external pins, SRC_CASC = neighbouring channel's overflow pulse.
package cnt_clk_pkg;
    localparam int NUM_RATES = 7;
    localparam int NUM_PINS  = 4;
    localparam int NUM_TAPS  = NUM_RATES - 1;
    localparam int DIV_W     = 2 * NUM_TAPS;
    localparam int CODE_W    = 3;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int SRC_W     = 4;
    localparam int LVL_W     = 1 << SRC_W;

    localparam logic [SRC_W-1:0] SRC_DIV1 = '0;
    localparam logic [SRC_W-1:0] SRC_PIN0 = SRC_W'(NUM_RATES);
    localparam logic [SRC_W-1:0] SRC_CASC = SRC_W'(NUM_RATES + NUM_PINS);

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_EVERY = 2'd1,
        KIND_LEVEL = 2'd2,
        KIND_PULSE = 2'd3
    } src_kind_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [1:0]        emode;
    } cfg_t;
endpackage

// File: rtl/ccs_prescaler.sv
// Module: ccs_prescaler
// Free-running binary divider shared by all channels. Tap j (0-based) is
// counter bit 2j+1, a square wave with period 4**(j+1) system clocks.
// Assumes: counting starts at 0 on the first edge after reset release.
module ccs_prescaler #(
    parameter int TAPS = 6,
    localparam int CW  = 2 * TAPS
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TAPS-1:0] taps
);
    logic [CW-1:0] div_q;

    // Advance the divider once per system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Pick the odd bits as the prescaled square waves.
    for (genvar j = 0; j < TAPS; j++) begin : g_tap
        assign taps[j] = div_q[2*j+1];
    end
endmodule

// File: rtl/ccs_pin_sync.sv
// Module: ccs_pin_sync
// Two-flop synchronizer for each asynchronous external clock pin.
// Assumes: the pins change no faster than the system clock can sample them.
module ccs_pin_sync #(
    parameter int PINS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_sync
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic meta_q, sync_q;

        // Bring one pin into the system-clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= pin_in[p];
                sync_q <= meta_q;
            end
        end

        assign pin_sync[p] = sync_q;
    end
endmodule

// File: rtl/ccs_edge_qual.sv
// Module: ccs_edge_qual
// Turns the selected source into a registered one-cycle count enable.
// Level sources are edge-detected per the edge mode. Pulse sources pass
// straight through. In a cycle where the configuration differs from the
// previous one, nothing is counted and the level history is re-sampled.
// Assumes: kind, lvl and pulse are already chosen for the current config.
module ccs_edge_qual
    import cnt_clk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cfg_t      cfg,
    input  src_kind_e kind,
    input  logic      lvl,
    input  logic      pulse,
    output logic      cnt_en
);
    cfg_t cfg_q;
    logic prev_q;
    logic cnt_en_q;
    logic rise, fall, edge_hit, evt, cfg_same;

    // Classify the transition of the selected level against the edge mode.
    always_comb begin
        rise     = lvl & ~prev_q;
        fall     = ~lvl & prev_q;
        edge_hit = cfg.emode[1] ? (rise | fall)
                 : (cfg.emode[0] ? fall : rise);
    end

    // Form the raw count event for the current source kind.
    always_comb begin
        case (kind)
            KIND_EVERY: evt = 1'b1;
            KIND_LEVEL: evt = edge_hit;
            KIND_PULSE: evt = pulse;
            default:    evt = 1'b0;
        endcase
        cfg_same = (cfg == cfg_q);
    end

    // Remember the configuration and level, and register the gated event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            prev_q   <= 1'b0;
            cnt_en_q <= 1'b0;
        end else begin
            cfg_q    <= cfg;
            prev_q   <= lvl;
            cnt_en_q <= evt & cfg_same;
        end
    end

    assign cnt_en = cnt_en_q;
endmodule

// File: rtl/cnt_clk_sel.sv
// Module: cnt_clk_sel (top)
// Count-clock selector for one timer channel. It decodes the source code
// through the per-channel map and legal mask, selects a divider tap, a
// synchronized pin, the undivided clock or the cascade pulse, and feeds the
// result to the edge qualifier. Phase counting, where built in, overrides all.
// Assumes: CODE_MAP holds a 4-bit source id per code, code i at bits 4i+3:4i.
module cnt_clk_sel
    import cnt_clk_pkg::*;
#(
    parameter logic [NUM_CODES*SRC_W-1:0] CODE_MAP   = 32'hB587_3210,
    parameter logic [NUM_CODES-1:0]       LEGAL_MASK = 8'hBF,
    parameter bit                         PHASE_OK   = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   psc_code,
    input  logic [1:0]          edge_mode,
    input  logic                phase_mode,
    input  logic [NUM_PINS-1:0] ext_pin,
    input  logic                casc_pulse,
    output logic                cnt_en
);
    logic [NUM_TAPS-1:0] taps;
    logic [NUM_PINS-1:0] pin_sync;
    logic [LVL_W-1:0]    lvl_all;
    logic [SRC_W-1:0]    src_id;
    logic                code_ok, phase_on, sel_lvl;
    src_kind_e           kind;
    cfg_t                cfg;

    ccs_prescaler #(.TAPS(NUM_TAPS)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps)
    );

    ccs_pin_sync #(.PINS(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (ext_pin),
        .pin_sync (pin_sync)
    );

    // The phase-counting override exists only on channels built with it.
    if (PHASE_OK) begin : g_phase
        assign phase_on = phase_mode;
    end else begin : g_nophase
        assign phase_on = 1'b0 & phase_mode;
    end

    // Gather every level source into one vector indexed by source id.
    always_comb begin
        lvl_all                      = '0;
        lvl_all[NUM_TAPS:1]          = taps;
        lvl_all[SRC_PIN0 +: NUM_PINS] = pin_sync;
    end

    // Decode the code into a source kind and the level it should watch.
    always_comb begin
        src_id  = CODE_MAP[int'(psc_code)*SRC_W +: SRC_W];
        code_ok = LEGAL_MASK[psc_code] && (src_id <= SRC_CASC);
        sel_lvl = lvl_all[src_id];
        if (!code_ok || phase_on)       kind = KIND_NONE;
        else if (src_id == SRC_DIV1)    kind = KIND_EVERY;
        else if (src_id == SRC_CASC)    kind = KIND_PULSE;
        else                            kind = KIND_LEVEL;
        cfg.code  = psc_code;
        cfg.emode = edge_mode;
    end

    ccs_edge_qual u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg    (cfg),
        .kind   (kind),
        .lvl    (sel_lvl),
        .pulse  (casc_pulse),
        .cnt_en (cnt_en)
    );
endmodule

// File: rtl/ccs_checker.sv
// Module: ccs_checker
// Port-level properties of the count-clock selector, bound to the top.
// Assumes: the same parameters as the instance it is bound to.
module ccs_checker
    import cnt_clk_pkg::*;
#(
    parameter logic [NUM_CODES*SRC_W-1:0] CODE_MAP   = 32'hB587_3210,
    parameter logic [NUM_CODES-1:0]       LEGAL_MASK = 8'hBF,
    parameter bit                         PHASE_OK   = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CODE_W-1:0]   psc_code,
    input logic [1:0]          edge_mode,
    input logic                phase_mode,
    input logic                casc_pulse,
    input logic                cnt_en
);
    logic [SRC_W-1:0] c_src;
    logic c_legal, c_div1, c_tap, c_casc, c_ph;

    // Decode the code independently for the properties.
    always_comb begin
        c_src   = CODE_MAP[int'(psc_code)*SRC_W +: SRC_W];
        c_legal = LEGAL_MASK[psc_code] && (c_src <= SRC_CASC);
        c_div1  = c_legal && (c_src == SRC_DIV1);
        c_tap   = c_legal && (c_src != SRC_DIV1) && (c_src < SRC_PIN0);
        c_casc  = c_legal && (c_src == SRC_CASC);
        c_ph    = PHASE_OK && phase_mode;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !cnt_en);

    assert_div1_every_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && c_div1 && !c_ph && $stable(psc_code) && $stable(edge_mode))
        |=> cnt_en);

    assert_casc_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && c_casc && !c_ph && $stable(psc_code) && $stable(edge_mode))
        |=> (cnt_en == $past(casc_pulse)));

    assert_illegal_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !c_legal |=> !cnt_en);

    assert_phase_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        c_ph |=> !cnt_en);

    assert_cfg_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!$stable(psc_code) || !$stable(edge_mode))) |=> !cnt_en);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_tap && cnt_en && $stable(psc_code)) |=> !cnt_en);
endmodule

bind cnt_clk_sel ccs_checker #(
    .CODE_MAP   (CODE_MAP),
    .LEGAL_MASK (LEGAL_MASK),
    .PHASE_OK   (PHASE_OK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .psc_code   (psc_code),
    .edge_mode  (edge_mode),
    .phase_mode (phase_mode),
    .casc_pulse (casc_pulse),
    .cnt_en     (cnt_en)
);

// File: tb/cnt_clk_sel_tb.sv
// Bench: sweeps every code and edge mode of the default channel, then runs
// phase-override and rapid-reconfiguration passes. Expected enables come
// from edge arithmetic and from the bench's own record of driven pins.
module cnt_clk_sel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] psc_code = '0;
    logic [1:0] edge_mode = '0;
    logic       phase_mode = 1'b0;
    logic [3:0] ext_pin = '0;
    logic       casc_pulse = 1'b0;
    logic       cnt_en;

    int n_cmp = 0;
    int n_bad = 0;
    int ticks = 0;
    bit done = 1'b0;
    logic [3:0] h1 = '0, h2 = '0, h3 = '0;
    logic [2:0] pcode = '0;
    logic [1:0] pmode = '0;
    logic       last_en = 1'b0;
    logic [15:0] lf = 16'hACE1;

    always #2 clk = ~clk;

    cnt_clk_sel u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .psc_code   (psc_code),
        .edge_mode  (edge_mode),
        .phase_mode (phase_mode),
        .ext_pin    (ext_pin),
        .casc_pulse (casc_pulse),
        .cnt_en     (cnt_en)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b (code=%0d mode=%0d tick=%0d)",
                     tag, act, exp, psc_code, edge_mode, ticks);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic [1:0] m,
                        input logic ph, input logic [3:0] pins, input logic cas);
        logic exp;
        string tag;
        int n;
        logic lv, pv;
        @(negedge clk);
        rst_n = 1'b1;
        psc_code = c; edge_mode = m; phase_mode = ph;
        ext_pin = pins; casc_pulse = cas;
        @(posedge clk);
        #1;
        if (ph) begin
            exp = 1'b0; tag = "R8";
        end else if (c != pcode || m != pmode) begin
            exp = 1'b0; tag = "R9";
        end else begin
            case (c)
                3'd0: begin exp = 1'b1; tag = "R2"; end
                3'd1, 3'd2, 3'd3: begin
                    n  = 4 << (2 * (int'(c) - 1));
                    lv = (ticks % n == n / 2);
                    pv = (ticks % n == 0) && (ticks > 0);
                    exp = m[1] ? (lv | pv) : (m[0] ? pv : lv);
                    tag = m[1] ? "R4" : "R3";
                end
                3'd4, 3'd5: begin
                    lv = h2[c - 3'd4];
                    pv = h3[c - 3'd4];
                    exp = m[1] ? (lv ^ pv) : (m[0] ? (!lv && pv) : (lv && !pv));
                    tag = "R5";
                end
                3'd6: begin exp = 1'b0; tag = "R7"; end
                default: begin exp = cas; tag = "R6"; end
            endcase
        end
        check(cnt_en, exp, tag);
        // R10: divided-rate pulses are isolated while the code is steady
        if (!ph && c >= 3'd1 && c <= 3'd3 && c == pcode && m == pmode && cnt_en === 1'b1)
            check(last_en && cnt_en, 1'b0, "R10");
        last_en = cnt_en;
        h3 = h2; h2 = h1; h1 = pins;
        pcode = c; pmode = m;
        ticks++;
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        // R1: quiet during reset
        repeat (5) begin
            @(negedge clk);
            rst_n = 1'b0;
            @(posedge clk);
            #1;
            check(cnt_en, 1'b0, "R1");
        end
        // Full sweep of codes against edge modes (R2..R7, R9, R10)
        for (int c = 0; c < 8; c++) begin
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < 300; s++) begin
                    lf = lfsr_next(lf);
                    step(3'(c), 2'(m), 1'b0, lf[3:0], lf[7]);
                end
            end
        end
        // R8: phase override on every code
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 40; s++) begin
                lf = lfsr_next(lf);
                step(3'(c), 2'd2, 1'b1, lf[3:0], lf[9]);
            end
        end
        // R9: rapid switching between two rates, then between a pin and a rate
        for (int s = 0; s < 120; s++) begin
            lf = lfsr_next(lf);
            step(((s / 3) % 2) ? 3'd3 : 3'd1, 2'd1, 1'b0, lf[3:0], 1'b0);
        end
        for (int s = 0; s < 120; s++) begin
            lf = lfsr_next(lf);
            step(((s / 4) % 2) ? 3'd4 : 3'd2, 2'd2, 1'b0, lf[3:0], 1'b0);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule